// File: doc/BRIEF.md
# Programmable Card Memory Cycle Sequencer

This block runs one word-wide memory access, either a read or a write, on a card-style parallel bus. The host gives a one-cycle start request along with the direction, an attribute-space flag, a timer-set choice, an address and write data. The block then drives the card's chip enables, attribute select, address and data lines, and its read and write strobes, through three timed phases. The setup phase comes first and puts the address and controls on the bus. The command phase asserts a strobe. The recovery phase releases the strobe and holds the address and data. At the end the block returns a one-cycle done pulse, and for a read it also returns the captured word.

Each phase length is `factor × count + 1` clock cycles. The values come from an 8-bit timing register. The upper two bits of that register pick a prescale factor and the lower six bits give the count. Two timer sets of three such registers can be written through a small indexed register port. During the command phase the card can request extra time by pulling an active-low wait line. When it releases the line, the strobe stays on for a short fixed hold.

Top module: `card_mem_seq`

## Requirements
- R1: The setup phase lasts S = F×N+1 cycles, with F and N taken from the selected set's setup register. For the whole cycle, `card_ce_n` is 2'b00, `card_attr_n` is the inverse of the latched attribute flag, and `card_addr` and `card_dout` carry the values latched at start.
- R2: Without a wait request, the strobe stays asserted for C = F×N+1 cycles, taken from the command register.
- R3: After the strobe is released, recovery lasts R = F×N+1 cycles, taken from the recovery register. Busy stays high during recovery.
- R4: Each timing register holds a prescale code in bits 7:6 (00 gives ×1, 01 gives ×16, 10 gives ×68, 11 gives ×256) and a count N in bits 5:0. Set 0 uses indices 3Ah, 3Bh and 3Ch, and set 1 uses 3Dh, 3Eh and 3Fh, for setup, command and recovery in that order. A write to any other index changes nothing. `host_set` chooses the set for each cycle.
- R5: After reset, both sets hold setup 01h, command 06h and recovery 03h. With these values a cycle has 2 setup, 7 command and 4 recovery cycles.
- R6: `card_wait_n` is low-active. It is honoured only when it is sampled low at a clock edge that ends strobe cycle k with k ≤ C−3, where cycles are counted from 0. At any later edge it is ignored and the strobe lasts C cycles.
- R7: Once a wait is honoured, the strobe stays on while wait stays low, and for two more cycles after wait is sampled high. If wait is held for W cycles starting at strobe cycle k, the strobe lasts k+W+3 cycles.
- R8: A read captures `card_din` at the clock edge that ends the last strobe cycle. The captured value appears on `host_rdata` while done is high.
- R9: `host_busy` is high from the cycle after a start is accepted through the last recovery cycle. A start that arrives while busy has no effect.
- R10: Reads pulse only `card_rd_n`, and writes pulse only `card_wr_n`. `card_doe` is high for the whole of a write cycle and stays low for reads.
- R11: `host_done` is high for exactly one cycle, the cycle right after the last recovery cycle. Busy is low in that cycle.
- R12: During reset and after it, while idle, the outputs are: busy 0, done 0, `card_ce_n` 2'b11, `card_attr_n` 1, both strobes 1 and `card_doe` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Timing register write enable |
| cfg_idx | input | 8 | Timing register index |
| cfg_wdata | input | 8 | Timing register write value |
| host_start | input | 1 | Start request, one cycle |
| host_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| host_attr | input | 1 | 1 for attribute space |
| host_set | input | 1 | Timer set choice |
| host_addr | input | ADDR_W | Cycle address |
| host_wdata | input | DATA_W | Write data |
| host_busy | output | 1 | Cycle in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read data |
| card_ce_n | output | 2 | Chip enables, active low |
| card_attr_n | output | 1 | Attribute select, active low |
| card_addr | output | ADDR_W | Card address |
| card_dout | output | DATA_W | Card write data |
| card_doe | output | 1 | Write data output enable |
| card_rd_n | output | 1 | Read strobe, active low |
| card_wr_n | output | 1 | Write strobe, active low |
| card_wait_n | input | 1 | Card wait request, active low |
| card_din | input | DATA_W | Card read data |

## Verification
The clock edge that samples a start begins setup cycle 0. Setup, command and recovery then follow each other with no gap. Done is due in the cycle right after the last recovery cycle, and the read data on that cycle equals the value of `card_din` during the last strobe cycle. The bench drives inputs and samples outputs at the falling edge, and measures each phase by counting falling edges in which the strobe and busy outputs show that phase. It drives wait and read data per strobe cycle index, so both the expected strobe length and the expected captured word follow arithmetically from k, W and C. After every done it checks one more cycle to confirm that no stray restart occurred.

// File: rtl/cms_pkg.sv
package cms_pkg;

  localparam int NVAL_W   = 6;
  localparam int PSEL_W   = 2;
  localparam int TREG_W   = NVAL_W + PSEL_W;
  localparam int MAX_FAC  = 256;
  localparam int CNT_W    = $clog2(MAX_FAC * ((1 << NVAL_W) - 1) + 1);
  localparam int NUM_SETS = 2;
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int NUM_PH   = 3;   // 0 setup, 1 command, 2 recovery

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_CMD   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_REC   = 3'd5
  } seq_state_t;

  // Reset value for each phase register.
  function automatic logic [TREG_W-1:0] def_treg(input int ph);
    case (ph)
      0:       def_treg = TREG_W'(8'h01);
      1:       def_treg = TREG_W'(8'h06);
      default: def_treg = TREG_W'(8'h03);
    endcase
  endfunction

endpackage

// File: rtl/cms_tmr_bank.sv
module cms_tmr_bank
  import cms_pkg::*;
#(
  parameter int              IDX_W    = 8,
  parameter logic [IDX_W-1:0] BASE_IDX = 8'h3A
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [TREG_W-1:0]                 cfg_wdata,
  input  logic [SET_W-1:0]                  set_use,
  output logic [NUM_PH-1:0][TREG_W-1:0]     cur_regs
);

  logic [NUM_SETS-1:0][NUM_PH-1:0][TREG_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      localparam logic [IDX_W-1:0] MY_IDX = BASE_IDX + IDX_W'(g * NUM_PH + p);
      logic              hit;
      logic [TREG_W-1:0] reg_d;

      always_comb begin
        hit   = cfg_we && (cfg_idx == MY_IDX);
        reg_d = hit ? cfg_wdata : regs_q[g][p];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g][p] <= def_treg(p);
        else if (hit) regs_q[g][p] <= reg_d;
      end
    end
  end

  assign cur_regs = regs_q[set_use];

endmodule

// File: rtl/cms_phase_len.sv
module cms_phase_len
  import cms_pkg::*;
(
  input  logic [TREG_W-1:0] treg,
  output logic [CNT_W-1:0]  len_m1   // phase length minus one = factor * count
);

  logic [CNT_W-1:0] nval;

  always_comb begin
    nval = CNT_W'(treg[NVAL_W-1:0]);
    case (treg[TREG_W-1 -: PSEL_W])
      2'd0:    len_m1 = nval;
      2'd1:    len_m1 = nval << 4;
      2'd2:    len_m1 = (nval << 6) + (nval << 2);
      default: len_m1 = nval << 8;
    endcase
  end

endmodule

// File: rtl/cms_seq.sv
module cms_seq
  import cms_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic              attr,
  input  logic [SET_W-1:0]  set_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [CNT_W-1:0]  s_len,
  input  logic [CNT_W-1:0]  c_len,
  input  logic [CNT_W-1:0]  r_len,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] din,
  output logic [SET_W-1:0]  set_use,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        ce_n,
  output logic              attr_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              rd_n,
  output logic              wr_n
);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, attr_q;
  logic [SET_W-1:0]  set_q;
  logic              load_en, cap_en, done_d;
  logic              busy_q, strb_q, busy_d, strb_d;
  logic              cmd_end;

  assign set_use = (st_q == ST_IDLE) ? set_in : set_q;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    cmd_end = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_SETUP;
          cnt_d   = s_len;
          load_en = 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = ST_CMD;
          cnt_d = c_len;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CMD: begin
        if (!wait_n && (cnt_q >= CNT_W'(2))) begin
          st_d = ST_WAIT;
        end else if (cnt_q == '0) begin
          cmd_end = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WAIT: begin
        if (wait_n) begin
          st_d  = ST_HOLD;
          cnt_d = CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) cmd_end = 1'b1;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_REC: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (cmd_end) begin
      st_d   = ST_REC;
      cnt_d  = r_len;
      cap_en = !wr_q;
    end
    busy_d = (st_d != ST_IDLE);
    strb_d = (st_d == ST_CMD) || (st_d == ST_WAIT) || (st_d == ST_HOLD);
  end

  // state and control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      strb_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      strb_q <= strb_d;
      done   <= done_d;
    end
  end

  // cycle parameters, loaded once per accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      attr_q  <= 1'b0;
      set_q   <= '0;
    end else if (load_en) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
      wr_q    <= dir_wr;
      attr_q  <= attr;
      set_q   <= set_in;
    end
  end

  // read capture at the edge ending the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= din;
  end

  assign busy   = busy_q;
  assign rdata  = rdata_q;
  assign ce_n   = {2{!busy_q}};
  assign attr_n = !(busy_q && attr_q);
  assign addr   = addr_q;
  assign dout   = wdata_q;
  assign doe    = busy_q && wr_q;
  assign rd_n   = !(strb_q && !wr_q);
  assign wr_n   = !(strb_q && wr_q);

endmodule

// File: rtl/card_mem_seq.sv
module card_mem_seq
  import cms_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [IDX_W-1:0] BASE_IDX = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  input  logic              host_start,
  input  logic              host_write,
  input  logic              host_attr,
  input  logic              host_set,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_busy,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [1:0]        card_ce_n,
  output logic              card_attr_n,
  output logic [ADDR_W-1:0] card_addr,
  output logic [DATA_W-1:0] card_dout,
  output logic              card_doe,
  output logic              card_rd_n,
  output logic              card_wr_n,
  input  logic              card_wait_n,
  input  logic [DATA_W-1:0] card_din
);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [SET_W-1:0]              set_use;
  logic [NUM_PH-1:0][TREG_W-1:0] cur_regs;
  logic [NUM_PH-1:0][CNT_W-1:0]  lens;

  cms_tmr_bank #(.IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (TREG_W'(cfg_wdata)),
    .set_use   (set_use),
    .cur_regs  (cur_regs)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_len
    cms_phase_len u_len (
      .treg   (cur_regs[p]),
      .len_m1 (lens[p])
    );
  end

  cms_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (host_start),
    .dir_wr   (host_write),
    .attr     (host_attr),
    .set_in   (SET_W'(host_set)),
    .addr_in  (host_addr),
    .wdata_in (host_wdata),
    .s_len    (lens[0]),
    .c_len    (lens[1]),
    .r_len    (lens[2]),
    .wait_n   (card_wait_n),
    .din      (card_din),
    .set_use  (set_use),
    .busy     (host_busy),
    .done     (host_done),
    .rdata    (host_rdata),
    .ce_n     (card_ce_n),
    .attr_n   (card_attr_n),
    .addr     (card_addr),
    .dout     (card_dout),
    .doe      (card_doe),
    .rd_n     (card_rd_n),
    .wr_n     (card_wr_n)
  );

endmodule

// File: rtl/cms_chk.sv
module cms_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_start,
  input logic              host_busy,
  input logic              host_done,
  input logic [1:0]        card_ce_n,
  input logic [ADDR_W-1:0] card_addr,
  input logic              card_doe,
  input logic              card_rd_n,
  input logic              card_wr_n
);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_rd_n && !card_wr_n));

  a_r1_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_rd_n || !card_wr_n) |-> (host_busy && card_ce_n == 2'b00));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && $past(host_busy)) |-> $stable(card_addr));

  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy) |-> $past(host_start));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_busy);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(host_busy));

  a_r10_doe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    card_doe |-> (host_busy && card_rd_n));

endmodule

bind card_mem_seq cms_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_start (host_start),
  .host_busy  (host_busy),
  .host_done  (host_done),
  .card_ce_n  (card_ce_n),
  .card_addr  (card_addr),
  .card_doe   (card_doe),
  .card_rd_n  (card_rd_n),
  .card_wr_n  (card_wr_n)
);

// File: tb/card_mem_seq_test.sv
module card_mem_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_idx = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          host_start = 1'b0, host_write = 1'b0, host_attr = 1'b0, host_set = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_busy, host_done;
  logic [DW-1:0] host_rdata;
  logic [1:0]    card_ce_n;
  logic          card_attr_n;
  logic [AW-1:0] card_addr;
  logic [DW-1:0] card_dout;
  logic          card_doe, card_rd_n, card_wr_n;
  logic          card_wait_n = 1'b1;
  logic [DW-1:0] card_din = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_mem_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .host_start(host_start), .host_write(host_write), .host_attr(host_attr),
    .host_set(host_set), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
    .card_ce_n(card_ce_n), .card_attr_n(card_attr_n), .card_addr(card_addr),
    .card_dout(card_dout), .card_doe(card_doe), .card_rd_n(card_rd_n),
    .card_wr_n(card_wr_n), .card_wait_n(card_wait_n), .card_din(card_din)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int plen(input logic [7:0] v);
    int f;
    case (v[7:6])
      2'd0: f = 1;
      2'd1: f = 16;
      2'd2: f = 68;
      default: f = 256;
    endcase
    return f * int'(v[5:0]) + 1;
  endfunction

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input bit set, input logic [7:0] s, input logic [7:0] c, input logic [7:0] r);
    logic [7:0] b;
    b = set ? 8'h3D : 8'h3A;
    cfg_write(b, s);
    cfg_write(b + 8'd1, c);
    cfg_write(b + 8'd2, r);
  endtask

  // Runs one cycle; counts phases at falling edges. errs counts bus-level mismatches.
  task automatic run(input bit wr, input bit set, input bit attr, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input int wk, input int ww, input logic [DW-1:0] dbase,
                     input bit extra_start,
                     output int s_n, output int c_n, output int r_n,
                     output logic [DW-1:0] rd, output int errs, output int restart);
    bit finished;
    bit pulsed;
    s_n = 0; c_n = 0; r_n = 0; errs = 0; rd = '0; restart = 0;
    finished = 1'b0; pulsed = 1'b0;
    @(negedge clk);
    host_start = 1'b1; host_write = wr; host_set = set; host_attr = attr;
    host_addr = a; host_wdata = d;
    @(negedge clk);
    host_start = 1'b0; host_write = ~wr; host_attr = ~attr; host_set = ~set;
    host_addr = ~a; host_wdata = ~d;
    for (int it = 0; it < 40000 && !finished; it++) begin
      if (host_start) host_start = 1'b0;
      if (host_done) begin
        rd = host_rdata;
        if (host_busy) errs++;
        finished = 1'b1;
      end else begin
        if (!host_busy) errs++;
        if (card_ce_n != 2'b00) errs++;
        if (card_attr_n != !attr) errs++;
        if (card_addr != a) errs++;
        if (wr && (card_doe != 1'b1 || card_dout != d || card_rd_n != 1'b1)) errs++;
        if (!wr && (card_doe != 1'b0 || card_wr_n != 1'b1)) errs++;
        if (!card_rd_n || !card_wr_n) begin
          if (r_n != 0) errs++;
          card_wait_n = !(c_n >= wk && c_n < wk + ww);
          card_din = dbase + DW'(c_n);
          c_n++;
          if (extra_start && !pulsed) begin
            host_start = 1'b1; pulsed = 1'b1;
          end
        end else if (c_n == 0) begin
          s_n++;
        end else begin
          r_n++;
          card_wait_n = 1'b1;
        end
        @(negedge clk);
      end
    end
    card_wait_n = 1'b1;
    host_start = 1'b0;
    if (!finished) errs++;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (host_busy || host_done || card_ce_n != 2'b11) restart++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s_n, c_n, r_n, errs, rs;
    logic [DW-1:0] rd;
    int nv [4] = '{0, 1, 2, 5};

    repeat (3) @(negedge clk);
    // R12: reset state while reset held
    check("R12", "busy in reset", host_busy, 0);
    check("R12", "ce_n in reset", card_ce_n, 3);
    check("R12", "strobes in reset", {card_rd_n, card_wr_n, card_attr_n}, 7);
    check("R12", "doe/done in reset", {card_doe, host_done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R12", "idle after reset", {host_busy, host_done, card_doe}, 0);

    // R5: defaults, both sets, read and write
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        run(w[0], s[0], s[0], 26'h2A5A5A5 + AW'(s), 16'hBEEF, 99, 0, 16'h1000, 1'b0,
            s_n, c_n, r_n, rd, errs, rs);
        check("R5", "default setup", s_n, 2);
        check("R5", "default command", c_n, 7);
        check("R5", "default recovery", r_n, 4);
        check("R1", "bus signals during cycle", errs, 0);
        if (w == 0) check("R8", "default read data", rd, 16'h1006);
      end
    end

    // R1/R2/R3/R4: sweep every phase, prescale and count on both sets
    for (int s = 0; s < 2; s++) begin
      for (int ph = 0; ph < 3; ph++) begin
        for (int p = 0; p < 4; p++) begin
          for (int n = 0; n < 4; n++) begin
            logic [7:0] v;
            v = {p[1:0], nv[n][5:0]};
            prog(s[0], ph == 0 ? v : 8'h01, ph == 1 ? v : 8'h01, ph == 2 ? v : 8'h01);
            prog(!s[0], 8'h02, 8'h02, 8'h02);
            run(n[0], s[0], p[0], AW'(ph * 16 + p * 4 + n), DW'(n * 7 + 3), 99, 0, 16'h0, 1'b0,
                s_n, c_n, r_n, rd, errs, rs);
            if (ph == 0) check("R1", "setup length", s_n, plen(v));
            else         check("R1", "setup length", s_n, 2);
            if (ph == 1) check("R2", "command length", c_n, plen(v));
            else         check("R2", "command length", c_n, 2);
            if (ph == 2) check("R3", "recovery length", r_n, plen(v));
            else         check("R3", "recovery length", r_n, 2);
            check("R10", "bus/doe per direction", errs, 0);
            check("R11", "no restart after done", rs, 0);
          end
        end
      end
    end

    // R4: largest count on the x1 scale
    prog(1'b0, 8'h3F, 8'h01, 8'h01);
    run(1'b1, 1'b0, 1'b0, 26'h1, 16'h1, 99, 0, 16'h0, 1'b0, s_n, c_n, r_n, rd, errs, rs);
    check("R4", "count 63 setup", s_n, 64);

    // R4: set selection with distinct sets, then ignored indices
    prog(1'b0, 8'h01, 8'h01, 8'h01);
    prog(1'b1, 8'h04, 8'h03, 8'h02);
    run(1'b0, 1'b1, 1'b0, 26'h5, 16'h0, 99, 0, 16'h0, 1'b0, s_n, c_n, r_n, rd, errs, rs);
    check("R4", "set1 lengths", s_n * 10000 + c_n * 100 + r_n, 50403);
    cfg_write(8'h39, 8'hFF);
    cfg_write(8'h40, 8'hFF);
    cfg_write(8'hBA, 8'hFF);
    run(1'b0, 1'b0, 1'b0, 26'h6, 16'h0, 99, 0, 16'h0, 1'b0, s_n, c_n, r_n, rd, errs, rs);
    check("R4", "set0 after stray writes", s_n * 10000 + c_n * 100 + r_n, 20202);
    run(1'b0, 1'b1, 1'b0, 26'h7, 16'h0, 99, 0, 16'h0, 1'b0, s_n, c_n, r_n, rd, errs, rs);
    check("R4", "set1 after stray writes", s_n * 10000 + c_n * 100 + r_n, 50403);

    // R6/R7/R8: wait window and hold sweep
    for (int n = 0; n < 7; n++) begin
      int cc;
      cc = n + 1;
      prog(1'b0, 8'h01, {2'b00, n[5:0]}, 8'h01);
      for (int k = 0; k <= cc; k++) begin
        for (int wi = 0; wi < 2; wi++) begin
          int ww, expc;
          ww = wi ? 3 : 1;
          expc = (k <= cc - 3) ? k + ww + 3 : cc;
          run(1'b0, 1'b0, 1'b1, AW'(k), 16'h0, k, ww, DW'(16'h4000 + n * 256), 1'b0,
              s_n, c_n, r_n, rd, errs, rs);
          if (k <= cc - 3) check("R7", "stretched strobe", c_n, expc);
          else             check("R6", "late wait ignored", c_n, expc);
          check("R8", "read capture", rd, DW'(16'h4000 + n * 256 + expc - 1));
          check("R3", "recovery after wait", r_n, 2);
        end
      end
    end

    // R9: start while busy ignored
    prog(1'b0, 8'h02, 8'h04, 8'h02);
    run(1'b1, 1'b0, 1'b0, 26'h15A, 16'h7E7E, 99, 0, 16'h0, 1'b1, s_n, c_n, r_n, rd, errs, rs);
    check("R9", "bus held during ignored start", errs, 0);
    check("R9", "no cycle from ignored start", rs, 0);
    check("R9", "lengths unchanged", s_n * 10000 + c_n * 100 + r_n, 30503);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule